// File: doc/BRIEF.md
# Two-Channel Timer Register Interface

This block is an APB register slave for a pair of down-counting timer channels. Each channel occupies a 32-byte window selected by address bit 5. A window holds the channel's reload value, live count, control byte, an interrupt acknowledge, the raw and masked event flags, and a second reload port. The second port changes the reload value without disturbing the running count. Every channel has its own interrupt line, and one more line is the OR of them.

A test-override pair near the top of the 4 KB space lets software drive the interrupt lines directly, so the wiring to an interrupt controller can be checked without waiting for a count to expire. A read-only run of identification bytes closes the map. Accesses complete with no wait states, and no access is ever flagged as an error.

Top module: `dtmr_apb_top`

## Requirements
- R1: Address bit 5 selects the channel (0x00 window = channel 0, 0x20 window = channel 1). The register at byte offset 0x0 holds the reload value and 0x4 the live count. 0x8 is control, 0xC is interrupt acknowledge (write-only), 0x10 is the raw event flag (bit 0), 0x14 is the masked event flag (bit 0) and 0x18 is the background reload.
- R2: A write to offset 0x0 sets both the reload value and the live count. A write to offset 0x18 sets only the reload value. A read of either offset returns the reload value.
- R3: Control is 8 bits wide with writable mask 0xEF, so bit 4 always reads 0. It resets to 0x20. Bit 7 enables counting and bit 5 enables the interrupt.
- R4: While bit 7 is set, the count falls by one each clock, and a count of 0 reloads from the reload value. Moving from 1 to 0 sets the raw event flag. While bit 7 is clear, the count holds.
- R5: The masked flag is the raw flag ANDed with control bit 5. Any write to offset 0xC clears the raw flag.
- R6: The test-enable register at 0xF00 keeps bit 0 only and reads back. The test-output register at 0xF04 keeps bits 1:0 and reads as zero. Both reset to zero.
- R7: When test enable is 1, interrupt line n follows test-output bit n one clock later. When test enable is 0, line n follows channel n's masked flag one clock later.
- R8: The combined interrupt equals the OR of the channel interrupt lines.
- R9: Words 0xFD0 through 0xFFC read, in ascending address order, 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Reads of unmapped or misaligned addresses return zero. Writes to them, and to the read-only offsets 0x4, 0x10 and 0x14, change no state.
- R11: PREADY is always 1 and PSLVERR is always 0.
- R12: After reset, each live count is 0xFFFFFFFF, each reload value is 0, and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data, registered in setup phase |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| irq_chan | output | NUM_CH | Per-channel interrupt lines |
| irq_any | output | 1 | OR of all channel lines |

## Verification
Four properties are checked on every cycle: the interrupt lines take the one-cycle-late path from the test-output bits or the masked flags, the combined line matches the OR, a load write lands in both reload and count, and a disabled count holds. Acknowledge clearing and the zero readback of unmapped reads are also checked each cycle. Only the bench scenarios can show that the address map is correct as a whole. They also show that the identification bytes appear in the right order, that writes to aliasing addresses such as 0x40 leave channel 0 untouched, and that the decrement rate holds across back-to-back reads.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  typedef enum logic [2:0] {
    RG_LOAD  = 3'd0,
    RG_VALUE = 3'd1,
    RG_CTRL  = 3'd2,
    RG_ACK   = 3'd3,
    RG_RAW   = 3'd4,
    RG_MSK   = 3'd5,
    RG_BGLD  = 3'd6,
    RG_NONE  = 3'd7
  } chan_reg_e;

  localparam int          CTRL_W    = 8;
  localparam logic [7:0]  CTRL_MASK = 8'hEF;
  localparam logic [7:0]  CTRL_RST  = 8'h20;
  localparam int          BIT_RUN   = 7;
  localparam int          BIT_IEN   = 5;
  localparam int          ID_WORDS  = 12;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = 8'h23;
      4'd5:    id_byte = 8'hB8;
      4'd6:    id_byte = 8'h1B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/dtmr_decode.sv
module dtmr_decode
  import dtmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_CH = 2
) (
  input  logic [ADDR_W-1:0] paddr,
  output logic              chan_hit,
  output logic [(NUM_CH>1 ? $clog2(NUM_CH) : 1)-1:0] ch_idx,
  output chan_reg_e         creg,
  output logic              itcr_hit,
  output logic              itop_hit,
  output logic              id_hit,
  output logic [3:0]        id_idx
);
  localparam int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int WORD_W  = ADDR_W - 2;
  localparam logic [WORD_W-1:0] ITCR_W = WORD_W'(12'hF00 >> 2);
  localparam logic [WORD_W-1:0] ITOP_W = WORD_W'(12'hF04 >> 2);
  localparam logic [WORD_W-1:0] ID_W   = WORD_W'(12'hFD0 >> 2);

  logic              aligned;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] id_off;

  assign aligned  = (paddr[1:0] == 2'b00);
  assign word     = paddr[ADDR_W-1:2];
  assign id_off   = word - ID_W;

  assign chan_hit = aligned && (paddr[ADDR_W-1:5+CH_BITS] == '0)
                    && (paddr[4:2] != 3'd7);
  assign ch_idx   = paddr[5 +: CH_BITS];
  assign creg     = chan_hit ? chan_reg_e'(paddr[4:2]) : RG_NONE;
  assign itcr_hit = aligned && (word == ITCR_W);
  assign itop_hit = aligned && (word == ITOP_W);
  assign id_hit   = aligned && (id_off < WORD_W'(ID_WORDS));
  assign id_idx   = id_off[3:0];
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
  import dtmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  chan_reg_e         rsel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_masked
);
  logic [DATA_W-1:0] load_q, value_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              raw_q;
  logic              run, expire, wr_load;

  assign run     = ctrl_q[BIT_RUN];
  assign expire  = run && (value_q == DATA_W'(1));
  assign wr_load = wr_en && (rsel == RG_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= '0;
      value_q <= '1;
      ctrl_q  <= CTRL_RST;
      raw_q   <= 1'b0;
    end else begin
      if (wr_load) begin
        load_q  <= wdata;
        value_q <= wdata;
      end else if (run) begin
        value_q <= (value_q == '0) ? load_q : value_q - 1'b1;
      end
      if (wr_en && rsel == RG_BGLD) load_q <= wdata;
      if (wr_en && rsel == RG_CTRL) ctrl_q <= wdata[CTRL_W-1:0] & CTRL_MASK;
      if (expire)                        raw_q <= 1'b1;
      else if (wr_en && rsel == RG_ACK)  raw_q <= 1'b0;
    end
  end

  assign irq_masked = raw_q && ctrl_q[BIT_IEN];

  always_comb begin
    case (rsel)
      RG_LOAD, RG_BGLD: rdata = load_q;
      RG_VALUE:         rdata = value_q;
      RG_CTRL:          rdata = DATA_W'(ctrl_q);
      RG_RAW:           rdata = DATA_W'(raw_q);
      RG_MSK:           rdata = DATA_W'(irq_masked);
      default:          rdata = '0;
    endcase
  end

  // R2
  load_both_chk: assert property (@(posedge clk) disable iff (rst)
    wr_load |=> (value_q == $past(wdata)) && (load_q == $past(wdata)));

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_load) |=> $stable(value_q));

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rsel == RG_ACK && !expire) |=> !raw_q);
endmodule

// File: rtl/dtmr_irq_out.sv
module dtmr_irq_out #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_itcr,
  input  logic              wr_itop,
  input  logic              wbit_en,
  input  logic [NUM_CH-1:0] wbits_out,
  input  logic [NUM_CH-1:0] masked_in,
  output logic              test_en,
  output logic [NUM_CH-1:0] irq_chan,
  output logic              irq_any
);
  logic [NUM_CH-1:0] test_bits;
  logic [NUM_CH-1:0] irq_nxt;

  assign irq_nxt = test_en ? test_bits : masked_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      test_en   <= 1'b0;
      test_bits <= '0;
      irq_chan  <= '0;
      irq_any   <= 1'b0;
    end else begin
      if (wr_itcr) test_en   <= wbit_en;
      if (wr_itop) test_bits <= wbits_out;
      irq_chan <= irq_nxt;
      irq_any  <= |irq_nxt;
    end
  end

  // R7
  test_drive_chk: assert property (@(posedge clk) disable iff (rst)
    test_en |=> irq_chan == $past(test_bits));

  // R7
  normal_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !test_en |=> irq_chan == $past(masked_in));

  // R8
  any_is_or_chk: assert property (@(posedge clk) disable iff (rst)
    irq_any == (|irq_chan));
endmodule

// File: rtl/dtmr_apb_top.sv
module dtmr_apb_top
  import dtmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [NUM_CH-1:0] irq_chan,
  output logic              irq_any
);
  localparam int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic               chan_hit, itcr_hit, itop_hit, id_hit;
  logic [CH_BITS-1:0] ch_idx;
  logic [3:0]         id_idx;
  chan_reg_e          creg;
  logic               setup_rd, access_wr, mapped, test_en;
  logic [NUM_CH-1:0]  masked;
  logic [DATA_W-1:0]  ch_rdata [NUM_CH];
  logic [DATA_W-1:0]  rd_nxt;

  dtmr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .paddr(paddr), .chan_hit(chan_hit), .ch_idx(ch_idx), .creg(creg),
    .itcr_hit(itcr_hit), .itop_hit(itop_hit), .id_hit(id_hit), .id_idx(id_idx)
  );

  assign setup_rd  = psel && !penable && !pwrite;
  assign access_wr = psel && penable && pwrite;
  assign mapped    = chan_hit || itcr_hit || itop_hit || id_hit;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dtmr_channel #(.DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst(rst),
      .wr_en(access_wr && chan_hit && (ch_idx == CH_BITS'(g))),
      .rsel(creg), .wdata(pwdata),
      .rdata(ch_rdata[g]), .irq_masked(masked[g])
    );
  end

  dtmr_irq_out #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst(rst),
    .wr_itcr(access_wr && itcr_hit), .wr_itop(access_wr && itop_hit),
    .wbit_en(pwdata[0]), .wbits_out(pwdata[NUM_CH-1:0]),
    .masked_in(masked), .test_en(test_en),
    .irq_chan(irq_chan), .irq_any(irq_any)
  );

  always_comb begin
    if (itcr_hit)      rd_nxt = DATA_W'(test_en);
    else if (id_hit)   rd_nxt = DATA_W'(id_byte(id_idx));
    else if (chan_hit) rd_nxt = ch_rdata[ch_idx];
    else               rd_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (setup_rd) prdata <= rd_nxt;
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (setup_rd && !mapped) |=> prdata == '0);
endmodule

// File: tb/dtmr_apb_top_tb.sv
module dtmr_apb_top_tb_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        pready, pslverr, irq_any;
  logic [1:0]  irq_chan;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rd, rd2;

  always #(CLK_NS/2) clk = ~clk;

  dtmr_apb_top dut_i (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irq_chan(irq_chan), .irq_any(irq_any)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rdw(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rdw(12'h004, rd); chk("R12 ch0 count", rd, 32'hFFFF_FFFF);
    rdw(12'h020, rd); chk("R12 ch1 reload", rd, 32'h0);
    rdw(12'h008, rd); chk("R3 ctrl reset", rd, 32'h20);
    rdw(12'hF00, rd); chk("R6 test enable reset", rd, 32'h0);
    chk("R12 irq lines", {29'd0, irq_any, irq_chan}, 32'h0);
    chk("R11 ready/err", {30'd0, pready, pslverr}, 32'h2);
  endtask

  task automatic t_load;
    wr(12'h000, 32'h1234_5678);
    wr(12'h020, 32'hCAFE_0001);
    rdw(12'h000, rd); chk("R1 ch0 reload", rd, 32'h1234_5678);
    rdw(12'h004, rd); chk("R2 ch0 count from load", rd, 32'h1234_5678);
    rdw(12'h024, rd); chk("R1 ch1 count", rd, 32'hCAFE_0001);
    wr(12'h038, 32'h55);
    rdw(12'h024, rd); chk("R2 bg reload keeps count", rd, 32'hCAFE_0001);
    rdw(12'h038, rd); chk("R2 bg read", rd, 32'h55);
    rdw(12'h020, rd); chk("R2 load read after bg", rd, 32'h55);
  endtask

  task automatic t_ctrl;
    wr(12'h028, 32'hFFFF_FF7F);
    rdw(12'h028, rd); chk("R3 ctrl mask", rd, 32'h6F);
    rdw(12'h008, rd); chk("R1 ch0 ctrl untouched", rd, 32'h20);
    wr(12'h028, 32'h20);
  endtask

  task automatic t_count;
    wr(12'h000, 32'd4);
    wr(12'h008, 32'h80);
    waitc(20);
    rdw(12'h010, rd); chk("R4 raw set on expiry", rd, 32'h1);
    rdw(12'h014, rd); chk("R5 masked off", rd, 32'h0);
    chk("R7 line low when masked", {31'd0, irq_chan[0]}, 32'h0);
    wr(12'h008, 32'hA0);
    waitc(3);
    chk("R7 line follows masked", {30'd0, irq_chan}, 32'h1);
    chk("R8 combined high", {31'd0, irq_any}, 32'h1);
    wr(12'h008, 32'h20);
    wr(12'h00C, 32'h0);
    rdw(12'h010, rd); chk("R5 ack clears raw", rd, 32'h0);
    waitc(2);
    chk("R8 combined low", {31'd0, irq_any}, 32'h0);
    wr(12'h000, 32'd1000);
    wr(12'h008, 32'h80);
    rdw(12'h004, rd); rdw(12'h004, rd2);
    chk("R4 decrement per clock", rd - rd2, 32'd3);
    wr(12'h008, 32'h00);
    rdw(12'h004, rd); waitc(5); rdw(12'h004, rd2);
    chk("R4 count holds when off", rd2, rd);
    wr(12'h00C, 32'h0);
  endtask

  task automatic t_test;
    wr(12'hF04, 32'hFFFF_FFFE);
    rdw(12'hF04, rd); chk("R6 test outputs read zero", rd, 32'h0);
    waitc(2);
    chk("R7 override idle when off", {30'd0, irq_chan}, 32'h0);
    wr(12'hF00, 32'hFFFF_FFFF);
    rdw(12'hF00, rd); chk("R6 test enable bit0", rd, 32'h1);
    chk("R7 override ch1", {30'd0, irq_chan}, 32'h2);
    chk("R8 combined in test", {31'd0, irq_any}, 32'h1);
    wr(12'hF04, 32'h1); waitc(1);
    chk("R7 override ch0", {30'd0, irq_chan}, 32'h1);
    wr(12'hF04, 32'h0); waitc(1);
    chk("R8 combined off in test", {31'd0, irq_any}, 32'h0);
    wr(12'hF00, 32'h0);
  endtask

  task automatic t_id;
    logic [7:0] exp_id [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h23, 8'hB8,
                                8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 12; i++) begin
      rdw(12'hFD0 + 12'(i*4), rd);
      chk("R9 id byte", rd, {24'd0, exp_id[i]});
    end
  endtask

  task automatic t_unmapped;
    logic [31:0] cnt;
    rdw(12'h01C, rd); chk("R10 read 0x1C", rd, 32'h0);
    rdw(12'h040, rd); chk("R10 read 0x40", rd, 32'h0);
    rdw(12'hF08, rd); chk("R10 read 0xF08", rd, 32'h0);
    rdw(12'hFCC, rd); chk("R10 read 0xFCC", rd, 32'h0);
    rdw(12'h001, rd); chk("R10 misaligned read", rd, 32'h0);
    rdw(12'h004, cnt);
    wr(12'h040, 32'hDEAD_BEEF);
    wr(12'h060, 32'hDEAD_BEEF);
    wr(12'h01C, 32'hDEAD_BEEF);
    wr(12'h004, 32'hDEAD_BEEF);
    wr(12'h010, 32'hDEAD_BEEF);
    wr(12'h002, 32'hDEAD_BEEF);
    rdw(12'h000, rd); chk("R10 reload unchanged", rd, 32'd1000);
    rdw(12'h004, rd); chk("R10 count unchanged", rd, cnt);
    rdw(12'h008, rd); chk("R10 ctrl unchanged", rd, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_ctrl();
    t_count();
    t_test();
    t_id();
    t_unmapped();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule